// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a free-running watchdog counter that escalates in two steps. When the selected period runs out, the first step sets a sticky watchdog flag. The flag is ANDed with an interrupt enable to form an interrupt request. At the same moment a fixed grace countdown of 512 clocks starts. If software has not restarted the watchdog by the end of that window, the second step drives a one-clock system reset pulse. This happens only when the reset-enable input is high at that moment. After the pulse the main counter starts again from zero.

Software restarts the watchdog with a one-clock strobe. The strobe zeroes the main counter and cancels a grace countdown that is in progress. The flag is separate: it only goes low on its own clear strobe. With reset-enable held low the block never resets anything. It then works as a long interval timer that sets the flag once per period. The period is 2^(17+3·sel) clocks, where sel is a 2-bit select. The `SCALE_SHIFT` parameter lowers every exponent by the same amount so that short runs are possible. The watchdog has its own flag and request line. Priority and vector handling belong to the interrupt controller that receives the request.

Top module: `wdt_two_stage`

## Requirements
- R1: The flag goes high on the clock edge where the counter has run for 2^(17+3·sel−SCALE_SHIFT) edges since the last restart, reset release or reset pulse. The select encodings 0, 1, 2 and 3 give exponents 17, 20, 23 and 26.
- R2: Suppose the select is changed to a period whose terminal count (period−1) is at or below the current count. The timeout then occurs on the very next edge.
- R3: A system reset pulse appears exactly GRACE_CLKS (512) clock edges after the timeout edge. This requires that no restart came in between and that reset-enable is 1 on that edge.
- R4: The interrupt request is high exactly when the flag is high and the interrupt enable is 1.
- R5: With reset-enable at 0, no reset pulse is produced. The counter keeps running, so the flag is set again one full period after the previous timeout.
- R6: The reset pulse lasts one clock. The main counter is zeroed on the pulse edge, so the next timeout comes one full period later.
- R7: A restart strobe zeroes the main counter and cancels any pending reset countdown.
- R8: Once set, the flag stays high until a clear strobe. If a timeout and a clear strobe fall on the same edge, the flag is set.
- R9: A restart strobe leaves the flag unchanged.
- R10: While the synchronous active-low reset is applied, the flag, the interrupt request and the reset pulse are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart_i | input | 1 | One-clock strobe that restarts the watchdog |
| tsel_i | input | 2 | Period select, exponent 17+3·sel−SCALE_SHIFT |
| irq_en_i | input | 1 | Watchdog interrupt enable |
| rst_en_i | input | 1 | Enables the second-stage reset pulse |
| flag_clr_i | input | 1 | One-clock strobe that clears the flag |
| wd_flag_o | output | 1 | Sticky watchdog timeout flag |
| wd_irq_o | output | 1 | Interrupt request (flag AND enable) |
| sys_rst_o | output | 1 | One-clock system reset pulse |

## Verification
The checker watches several properties on every clock. The flag must follow each internal timeout and must hold until it is cleared. The request must be gated by its enable. Every reset pulse must be one clock wide, must come exactly 512 clocks after an uncancelled timeout, and must have reset-enable behind it. A restart must always suppress the pulse. The absolute period for each select value and the early timeout when the select is lowered can only be shown by the bench's timed scenarios. The same holds for the counter restarting after a pulse and for the free-running behaviour when reset is disabled. In those scenarios a scoreboard matches every flag rise and every pulse to a predicted clock number.

// File: rtl/wdt_pkg.sv
// Shared types and helpers for the two-stage watchdog.
// Assumes: exponents stay well below 64 after scaling.
package wdt_pkg;

    // Grace countdown state.
    typedef enum logic {
        GR_IDLE  = 1'b0,
        GR_ARMED = 1'b1
    } grace_state_e;

    // Exponent of the period chosen by a select code.
    function automatic int unsigned sel_exponent(
        input int unsigned sel,
        input int unsigned base,
        input int unsigned step,
        input int unsigned shift
    );
        return base + step * sel - shift;
    endfunction

endpackage

// File: rtl/wdt_period_sel.sv
// Turns the period select into the terminal count (period minus one).
// Assumes: CNT_W is the largest exponent, so every terminal fits.
module wdt_period_sel
    import wdt_pkg::*;
#(
    parameter int unsigned TSEL_W      = 2,
    parameter int unsigned BASE_EXP    = 17,
    parameter int unsigned EXP_STEP    = 3,
    parameter int unsigned SCALE_SHIFT = 0,
    parameter int unsigned CNT_W       = 26
) (
    input  logic [TSEL_W-1:0] tsel_i,
    output logic [CNT_W-1:0]  terminal_o
);
    localparam int unsigned NSEL = 1 << TSEL_W;

    logic [CNT_W-1:0] term_tbl [NSEL];

    // One terminal constant per select code.
    for (genvar i = 0; i < NSEL; i++) begin : g_term
        localparam int unsigned EXP_I = sel_exponent(i, BASE_EXP, EXP_STEP, SCALE_SHIFT);
        assign term_tbl[i] = CNT_W'((64'd1 << EXP_I) - 64'd1);
    end

    // Select the active terminal count.
    assign terminal_o = term_tbl[tsel_i];

endmodule

// File: rtl/wdt_main_counter.sv
// Main up-counter. It signals a timeout when the count reaches or passes the terminal.
// Assumes: restart takes priority and masks the timeout on the same edge.
module wdt_main_counter #(
    parameter int unsigned CNT_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] terminal_i,
    output logic             timeout_o
);
    logic [CNT_W-1:0] cnt_q;

    // Timeout when the terminal is reached or passed (the select may have been lowered).
    assign timeout_o = !restart_i && (cnt_q >= terminal_i);

    // Count up; go back to zero on restart, on a reset pulse or on a timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i || clear_i || timeout_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_grace_timer.sv
// Grace countdown between a timeout and the system reset pulse.
// Assumes: the period is longer than GRACE_CLKS, so no timeout comes while armed.
module wdt_grace_timer
    import wdt_pkg::*;
#(
    parameter int unsigned GRACE_CLKS = 512,
    parameter int unsigned GRACE_W    = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic timeout_i,
    input  logic rst_en_i,
    output logic fire_o,
    output logic sys_rst_o
);
    grace_state_e       state_q;
    logic [GRACE_W-1:0] left_q;
    logic               sys_rst_q;
    logic               expire;

    // The window closes on the edge where the remaining count is zero.
    assign expire    = (state_q == GR_ARMED) && (left_q == '0);
    assign fire_o    = expire && rst_en_i && !restart_i;
    assign sys_rst_o = sys_rst_q;

    // Arm on timeout, count down, then fire or give up; a restart cancels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= GR_IDLE;
            left_q    <= '0;
            sys_rst_q <= 1'b0;
        end else begin
            sys_rst_q <= 1'b0;
            if (restart_i) begin
                state_q <= GR_IDLE;
            end else if (expire) begin
                state_q   <= GR_IDLE;
                sys_rst_q <= rst_en_i;
            end else if (timeout_i) begin
                state_q <= GR_ARMED;
                left_q  <= GRACE_W'(GRACE_CLKS - 1);
            end else if (state_q == GR_ARMED) begin
                left_q <= left_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdt_flag_ctrl.sv
// Sticky watchdog flag and its gated interrupt request.
// Assumes: a set wins over a clear on the same edge.
module wdt_flag_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_q;

    // Set on timeout, clear only on the software strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & irq_en_i;

endmodule

// File: rtl/wdt_two_stage.sv
// Two-stage watchdog: the flag and request come first, the reset pulse after a grace window.
// Assumes: 2^(BASE_EXP-SCALE_SHIFT) > GRACE_CLKS >= 2; synchronous active-low reset.
module wdt_two_stage #(
    parameter int unsigned TSEL_W      = 2,
    parameter int unsigned BASE_EXP    = 17,
    parameter int unsigned EXP_STEP    = 3,
    parameter int unsigned SCALE_SHIFT = 0,
    parameter int unsigned GRACE_CLKS  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic [TSEL_W-1:0] tsel_i,
    input  logic              irq_en_i,
    input  logic              rst_en_i,
    input  logic              flag_clr_i,
    output logic              wd_flag_o,
    output logic              wd_irq_o,
    output logic              sys_rst_o
);
    localparam int unsigned NSEL    = 1 << TSEL_W;
    localparam int unsigned CNT_W   = BASE_EXP + EXP_STEP * (NSEL - 1) - SCALE_SHIFT;
    localparam int unsigned GRACE_W = $clog2(GRACE_CLKS);

    logic [CNT_W-1:0] terminal;
    logic             timeout_evt;
    logic             rst_fire;

    wdt_period_sel #(
        .TSEL_W(TSEL_W), .BASE_EXP(BASE_EXP), .EXP_STEP(EXP_STEP),
        .SCALE_SHIFT(SCALE_SHIFT), .CNT_W(CNT_W)
    ) u_psel (
        .tsel_i(tsel_i), .terminal_o(terminal)
    );

    wdt_main_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .clear_i(rst_fire),
        .terminal_i(terminal), .timeout_o(timeout_evt)
    );

    wdt_grace_timer #(.GRACE_CLKS(GRACE_CLKS), .GRACE_W(GRACE_W)) u_grace (
        .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .timeout_i(timeout_evt),
        .rst_en_i(rst_en_i), .fire_o(rst_fire), .sys_rst_o(sys_rst_o)
    );

    wdt_flag_ctrl u_flag (
        .clk(clk), .rst_n(rst_n), .set_i(timeout_evt), .clr_i(flag_clr_i),
        .irq_en_i(irq_en_i), .flag_o(wd_flag_o), .irq_o(wd_irq_o)
    );

endmodule

// File: rtl/wdt_two_stage_chk.sv
// Checker for the two-stage watchdog, attached to the top module with a bind.
// It counts clocks since the last timeout so the grace window is checked without deep $past.
module wdt_two_stage_chk #(
    parameter int unsigned GRACE_CLKS = 512
) (
    input logic clk,
    input logic rst_n,
    input logic restart_i,
    input logic rst_en_i,
    input logic irq_en_i,
    input logic flag_clr_i,
    input logic timeout_evt,
    input logic wd_flag_o,
    input logic wd_irq_o,
    input logic sys_rst_o
);
    logic armed_q;
    int unsigned since_q;

    // Track clocks elapsed since an uncancelled timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            since_q <= 0;
        end else if (restart_i || sys_rst_o) begin
            armed_q <= 1'b0;
        end else if (timeout_evt) begin
            armed_q <= 1'b1;
            since_q <= 0;
        end else if (armed_q && since_q < GRACE_CLKS) begin
            since_q <= since_q + 1;
        end
    end

    a_r1_flag_follows_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_evt |=> wd_flag_o);
    a_r3_grace_exact: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> (armed_q && since_q == GRACE_CLKS));
    a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        wd_irq_o |-> (irq_en_i && wd_flag_o));
    a_r4_irq_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_flag_o && irq_en_i) |-> wd_irq_o);
    a_r5_reset_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> $past(rst_en_i));
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |=> !sys_rst_o);
    a_r7_restart_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !sys_rst_o);
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_flag_o && !flag_clr_i) |=> wd_flag_o);
    a_r8_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !timeout_evt) |=> !wd_flag_o);

endmodule

bind wdt_two_stage wdt_two_stage_chk #(.GRACE_CLKS(GRACE_CLKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .rst_en_i(rst_en_i),
    .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i), .timeout_evt(timeout_evt),
    .wd_flag_o(wd_flag_o), .wd_irq_o(wd_irq_o), .sys_rst_o(sys_rst_o)
);

// File: tb/test_wdt_two_stage.sv
// Scoreboard bench: the driver queues predicted flag rises and reset pulses with their clock numbers;
// the monitor pops and compares them as they happen.
module test_wdt_two_stage;
    localparam int SHIFT = 7;
    localparam int GRACE = 512;
    localparam int P0 = 1 << (17 - SHIFT);
    localparam int P1 = 1 << (20 - SHIFT);
    localparam int P2 = 1 << (23 - SHIFT);
    localparam int EV_FLAG = 1;
    localparam int EV_RST  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic restart_i = 1'b0;
    logic [1:0] tsel_i = 2'd0;
    logic irq_en_i = 1'b1;
    logic rst_en_i = 1'b1;
    logic flag_clr_i = 1'b0;
    logic wd_flag_o, wd_irq_o, sys_rst_o;

    always #4 clk = ~clk;

    wdt_two_stage #(.SCALE_SHIFT(SHIFT), .GRACE_CLKS(GRACE)) i_wdt_two_stage (
        .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .tsel_i(tsel_i),
        .irq_en_i(irq_en_i), .rst_en_i(rst_en_i), .flag_clr_i(flag_clr_i),
        .wd_flag_o(wd_flag_o), .wd_irq_o(wd_irq_o), .sys_rst_o(sys_rst_o)
    );

    int cyc = 0;
    int errors = 0;
    int checks = 0;
    int rst_seen = 0;
    bit done = 1'b0;
    int q_kind[$];
    int q_cyc[$];
    string q_req[$];
    logic prev_flag = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_ev(input int kind, input int at, input string req);
        q_kind.push_back(kind);
        q_cyc.push_back(at);
        q_req.push_back(req);
    endtask

    task automatic observe(input int kind);
        checks++;
        if (q_kind.size() == 0) begin
            errors++;
            $display("FAIL R7 unexpected event kind=%0d at cycle %0d, expected none", kind, cyc);
        end else begin
            int k, c;
            string r;
            k = q_kind.pop_front();
            c = q_cyc.pop_front();
            r = q_req.pop_front();
            if (k != kind || c != cyc) begin
                errors++;
                $display("FAIL %s event actual kind=%0d cycle=%0d expected kind=%0d cycle=%0d",
                         r, kind, cyc, k, c);
            end
        end
    endtask

    // Monitor: sample outputs at the falling edge and match them to the scoreboard.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_flag = 1'b0;
        end else if (!done) begin
            if (wd_flag_o && !prev_flag) observe(EV_FLAG);
            if (sys_rst_o) begin
                rst_seen++;
                observe(EV_RST);
            end
            prev_flag = wd_flag_o;
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Restart strobe; ref is the edge on which the counter becomes zero.
    task automatic do_restart(output int ref_edge);
        @(negedge clk);
        restart_i = 1'b1;
        ref_edge = cyc + 1;
        @(negedge clk);
        restart_i = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        flag_clr_i = 1'b1;
        @(negedge clk);
        flag_clr_i = 1'b0;
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int r, r2, seen;
        // R10: reset state
        repeat (5) @(negedge clk);
        chk("R10", wd_flag_o, 0, "flag in reset");
        chk("R10", wd_irq_o, 0, "irq in reset");
        chk("R10", sys_rst_o, 0, "pulse in reset");

        // R1, R3, R6: sel=0, full escalation
        @(negedge clk);
        rst_n = 1'b1;
        r = cyc;
        expect_ev(EV_FLAG, r + P0, "R1");
        expect_ev(EV_RST, r + P0 + GRACE, "R3");
        wait_to(r + P0 - 1);
        chk("R1", wd_flag_o, 0, "flag one clock before timeout");
        wait_to(r + P0);
        chk("R1", wd_flag_o, 1, "flag at timeout");
        chk("R4", wd_irq_o, 1, "irq with enable set");
        wait_to(r + P0 + GRACE - 1);
        chk("R3", sys_rst_o, 0, "pulse one clock early");
        wait_to(r + P0 + GRACE);
        chk("R3", sys_rst_o, 1, "pulse at grace end");
        wait_to(r + P0 + GRACE + 1);
        chk("R6", sys_rst_o, 0, "pulse width");
        chk("R8", wd_flag_o, 1, "flag held without clear");
        pulse_clr();
        chk("R8", wd_flag_o, 0, "flag after clear");
        // R6: counter restarted by the pulse
        expect_ev(EV_FLAG, r + 2 * P0 + GRACE, "R6");
        wait_to(r + 2 * P0 + GRACE + 10);
        chk("R6", wd_flag_o, 1, "flag one period after pulse");
        seen = rst_seen;
        do_restart(r2);
        chk("R9", wd_flag_o, 1, "flag after restart");
        wait_to(r + 2 * P0 + 2 * GRACE + 20);
        chk("R7", rst_seen, seen, "pulses after restart in grace");
        pulse_clr();

        // R4: interrupt masked, sel=1 period
        irq_en_i = 1'b0;
        tsel_i = 2'd1;
        do_restart(r);
        expect_ev(EV_FLAG, r + P1, "R1");
        expect_ev(EV_RST, r + P1 + GRACE, "R3");
        wait_to(r + P1 + 1);
        chk("R4", wd_flag_o, 1, "flag with irq disabled");
        chk("R4", wd_irq_o, 0, "irq masked");
        wait_to(r + P1 + GRACE + 2);
        pulse_clr();
        irq_en_i = 1'b1;

        // R5: reset disabled, long timer keeps running
        rst_en_i = 1'b0;
        tsel_i = 2'd0;
        do_restart(r);
        seen = rst_seen;
        expect_ev(EV_FLAG, r + P0, "R5");
        wait_to(r + P0 + 6);
        pulse_clr();
        expect_ev(EV_FLAG, r + 2 * P0, "R5");
        wait_to(r + 2 * P0 + GRACE + 80);
        chk("R5", rst_seen, seen, "pulses with reset disabled");
        chk("R5", wd_flag_o, 1, "flag after second period");
        pulse_clr();

        // R7: restart mid-count moves the timeout
        rst_en_i = 1'b1;
        do_restart(r);
        wait_to(r + 500);
        do_restart(r2);
        expect_ev(EV_FLAG, r2 + P0, "R7");
        wait_to(r + P0 + 20);
        chk("R7", wd_flag_o, 0, "no timeout at old deadline");
        wait_to(r2 + P0 + 6);
        pulse_clr();
        do_restart(r);

        // R2: lowering the select below the current count
        tsel_i = 2'd1;
        do_restart(r);
        wait_to(r + 2000);
        tsel_i = 2'd0;
        expect_ev(EV_FLAG, r + 2001, "R2");
        wait_to(r + 2002);
        chk("R2", wd_flag_o, 1, "immediate timeout after select change");
        pulse_clr();
        do_restart(r);

        // R1 sel=2 period with reset disabled
        rst_en_i = 1'b0;
        tsel_i = 2'd2;
        do_restart(r);
        expect_ev(EV_FLAG, r + P2, "R1");
        wait_to(r + P2 - 1);
        chk("R1", wd_flag_o, 0, "sel2 flag before period");
        wait_to(r + P2);
        chk("R1", wd_flag_o, 1, "sel2 flag at period");
        pulse_clr();

        // R8: set wins over a clear on the same edge
        tsel_i = 2'd0;
        do_restart(r);
        expect_ev(EV_FLAG, r + P0, "R8");
        wait_to(r + P0 - 1);
        flag_clr_i = 1'b1;
        @(negedge clk);
        flag_clr_i = 1'b0;
        chk("R8", wd_flag_o, 1, "set beats clear");
        pulse_clr();

        @(negedge clk);
        done = 1'b1;
        rst_n = 1'b0;
        chk("R1", q_kind.size(), 0, "events still pending");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule